// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-facing control and status register set of one descriptor-driven DMA channel. A processor reaches it over a plain 32-bit register bus: a write strobe, a read strobe, an 8-bit offset inside the channel window, and write data. Read data is registered and valid in the cycle after the read strobe. The decode of a channel's window from the full address is done outside the block. Only the low 8 bits reach it.

The block keeps five pointer registers that the descriptor and data engines use: the current data pointer, the saved descriptor pointer, the saved buffer pointer, the group pointer and the group-down pointer. It also holds the channel configuration and a small interrupt unit with raw, mask and masked views. A one-hot channel state machine (reset, stopped, running) and an end-of-list flag complete the state. Stream commands written by software are decoded into descriptor-load and context-load requests. Each request is held to the external engine until that engine acknowledges it. The acknowledge may also start the channel. A write to the command register performs a conditional continue. The interrupt output is a level that is high while any unmasked raw interrupt is pending.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every readable register returns zero, except status, which returns 0x101. The state output is 3'b001, and `irq`, `ld_data_req` and `ld_ctx_req` are low.
- R2: The pointer registers at offsets 0x00, 0x58, 0x5C, 0x60 and 0x7C read back the last value written. Configuration (0x84, two bits) and interrupt mask (0x8C) also read back.
- R3: The state is one-hot: reset = 3'b001, stopped = 3'b010, running = 3'b100. A configuration write with bit 1 set enters stopped. A configuration write with bit 0 clear enters reset, and this wins when both apply. Any other configuration write leaves the state unchanged.
- R4: Status (0x88) returns the state in bits 2:0, the end-of-list flag in bit 5, the error flag in bit 6, and the command source in bits 9:8. The source is 1 after reset and 2 once a stream command has been written.
- R5: A stream command write (0x9C) uses bits 9:0. If any bit of mask 0x140 is set, `ld_data_req` rises and holds until `ld_data_ack`. On that acknowledge the channel starts only if bit 5 (0x20) was also set. Bit 9 (0x200) raises `ld_ctx_req`, held until `ld_ctx_ack`, and that acknowledge always starts the channel.
- R6: A start moves the state to running and clears the end-of-list flag. It only happens if `client_present` is high at the acknowledge; otherwise the state is left as it was.
- R7: A write to the command register (0x80) raises `ld_data_req` only when all of these hold: configuration bit 0 is set, `client_present` is high, configuration bit 1 is clear, the state is running, and `desc_eol` is high. On the acknowledge of that reload the channel starts if `desc_eol` is then low and the end-of-list flag is set. A command write failing any of these conditions raises no request.
- R8: Each `intr_set` bit sets the same bit of the raw interrupt (0x94). A write to acknowledge (0x90) clears the raw bits written as one, and a set in the same cycle wins. The acknowledge register reads zero. The masked value (0x98) is raw AND mask, and `irq` is high exactly while it is nonzero.
- R9: A command write with any bit above bit 0 set, or a stream command write with any bit above bit 9 set, sets the error flag. Only the defined bits are stored: bit 0 of command, bits 9:0 of stream command. Upper bits alone cause no request. A status read returns the flag and then clears it.
- R10: A pulse on `eol_hit` sets the end-of-list flag.
- R11: Writes to status, raw interrupt, masked interrupt and undecoded offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register offset inside the channel window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| client_present | input | 1 | A data client is attached to the channel |
| desc_eol | input | 1 | End-of-list bit of the currently loaded data descriptor |
| eol_hit | input | 1 | Engine reached the end of the descriptor list |
| intr_set | input | IRQ_W | Per-bit interrupt set pulses from the engines |
| ld_data_req | output | 1 | Request to load the data descriptor |
| ld_data_ack | input | 1 | Acknowledge of the data descriptor load |
| ld_ctx_req | output | 1 | Request to load the context descriptor |
| ld_ctx_ack | input | 1 | Acknowledge of the context load |
| saved_data_ptr | output | PTR_W | Saved descriptor pointer for the fetch engine |
| group_down_ptr | output | PTR_W | Group-down pointer for the fetch engine |
| chan_state | output | 3 | One-hot channel state |
| irq | output | 1 | Level interrupt |

## Verification
Some properties are checked on every cycle. The state must always stay one-hot. A pending load request must hold until its acknowledge. An acknowledge write must leave the written raw bits clear. `eol_hit` must set the end-of-list flag. The state must never become running while no client is attached, and `irq` may only rise after an interrupt set or a mask write. Other behaviour is only visible in the bench's scenarios, which compare against a behavioural model on every clock. These cover the burst-versus-plain data load and the full conditional continue sequence. They also cover configuration priority, read-to-clear of the error flag, same-cycle set-versus-acknowledge, and the exact packing of the status word.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;

    localparam int BUS_W  = 32;
    localparam int OFS_W  = 8;
    localparam int SC_W   = 10;
    localparam int NPTR   = 5;

    localparam logic [OFS_W-1:0] OFS_CMD   = 8'h80;
    localparam logic [OFS_W-1:0] OFS_CFG   = 8'h84;
    localparam logic [OFS_W-1:0] OFS_STAT  = 8'h88;
    localparam logic [OFS_W-1:0] OFS_IMASK = 8'h8C;
    localparam logic [OFS_W-1:0] OFS_IACK  = 8'h90;
    localparam logic [OFS_W-1:0] OFS_IRAW  = 8'h94;
    localparam logic [OFS_W-1:0] OFS_IMSKD = 8'h98;
    localparam logic [OFS_W-1:0] OFS_SCMD  = 8'h9C;

    localparam logic [SC_W-1:0] SC_LOAD_D = 10'h140;
    localparam logic [SC_W-1:0] SC_BURST  = 10'h020;
    localparam logic [SC_W-1:0] SC_LOAD_C = 10'h200;

    localparam logic [1:0] SRC_RESET = 2'd1;
    localparam logic [1:0] SRC_SW    = 2'd2;

    typedef enum logic [2:0] {
        CH_RST  = 3'b001,
        CH_STOP = 3'b010,
        CH_RUN  = 3'b100
    } ch_state_e;

    typedef struct packed {
        logic load_d;
        logic burst;
        logic load_c;
    } scmd_t;

    // pointer slot i -> register offset
    function automatic logic [OFS_W-1:0] ptr_ofs(input int i);
        case (i)
            0:       return 8'h00;
            1:       return 8'h58;
            2:       return 8'h5C;
            3:       return 8'h60;
            default: return 8'h7C;
        endcase
    endfunction

    function automatic scmd_t decode_scmd(input logic [SC_W-1:0] v);
        scmd_t s;
        s.load_d = |(v & SC_LOAD_D);
        s.burst  = |(v & SC_BURST);
        s.load_c = |(v & SC_LOAD_C);
        return s;
    endfunction

    function automatic logic [BUS_W-1:0] pack_status(input logic [2:0] st,
                                                     input logic       eol,
                                                     input logic       err,
                                                     input logic [1:0] src);
        return {22'b0, src, 1'b0, err, eol, 2'b0, st};
    endfunction

endpackage

// File: rtl/dmacr_irq.sv
module dmacr_irq #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] set_i,
    input  logic             ack_wr,
    input  logic             mask_wr,
    input  logic [IRQ_W-1:0] wbits,
    output logic [IRQ_W-1:0] raw_o,
    output logic [IRQ_W-1:0] mask_o,
    output logic [IRQ_W-1:0] masked_o,
    output logic             irq_o
);

    logic [IRQ_W-1:0] raw_q;
    logic [IRQ_W-1:0] mask_q;
    logic [IRQ_W-1:0] keep;

    assign keep = ack_wr ? ~wbits : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & keep) | set_i;
            if (mask_wr) mask_q <= wbits;
        end
    end

    assign raw_o    = raw_q;
    assign mask_o   = mask_q;
    assign masked_o = raw_q & mask_q;
    assign irq_o    = |masked_o;

endmodule

// File: rtl/dmacr_fsm.sv
module dmacr_fsm
    import dmacr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_wr,
    input  logic      cfg_en_new,
    input  logic      cfg_stop_new,
    input  logic      cfg_en_q,
    input  logic      cfg_stop_q,
    input  logic      scmd_wr,
    input  scmd_t     scmd,
    input  logic      cmd_wr,
    input  logic      client,
    input  logic      desc_eol,
    input  logic      eol_hit,
    input  logic      d_ack,
    input  logic      c_ack,
    output ch_state_e state_o,
    output logic      eol_o,
    output logic      d_req,
    output logic      c_req
);

    ch_state_e st_q;
    logic eol_q, dreq_q, creq_q, dstart_q, dcont_q;
    logic d_done, c_done, start_go, cont_ok;

    assign d_done   = dreq_q & d_ack;
    assign c_done   = creq_q & c_ack;
    assign start_go = client &
                      ((d_done & (dstart_q | (dcont_q & ~desc_eol & eol_q))) | c_done);
    assign cont_ok  = cmd_wr & cfg_en_q & client & ~cfg_stop_q &
                      (st_q == CH_RUN) & desc_eol;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= CH_RST;
            eol_q    <= 1'b0;
            dreq_q   <= 1'b0;
            creq_q   <= 1'b0;
            dstart_q <= 1'b0;
            dcont_q  <= 1'b0;
        end else begin
            if (d_done) dreq_q <= 1'b0;
            if (c_done) creq_q <= 1'b0;
            if (scmd_wr && scmd.load_d) begin
                dreq_q   <= 1'b1;
                dstart_q <= scmd.burst;
                dcont_q  <= 1'b0;
            end else if (cont_ok) begin
                dreq_q   <= 1'b1;
                dstart_q <= 1'b0;
                dcont_q  <= 1'b1;
            end
            if (scmd_wr && scmd.load_c) creq_q <= 1'b1;
            if (start_go) begin
                st_q  <= CH_RUN;
                eol_q <= 1'b0;
            end
            if (eol_hit) eol_q <= 1'b1;
            if (cfg_wr) begin
                if (cfg_stop_new) st_q <= CH_STOP;
                if (!cfg_en_new)  st_q <= CH_RST;
            end
        end
    end

    assign state_o = st_q;
    assign eol_o   = eol_q;
    assign d_req   = dreq_q;
    assign c_req   = creq_q;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dmacr_pkg::*;
#(
    parameter int IRQ_W = 4,
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             client_present,
    input  logic             desc_eol,
    input  logic             eol_hit,
    input  logic [IRQ_W-1:0] intr_set,
    output logic             ld_data_req,
    input  logic             ld_data_ack,
    output logic             ld_ctx_req,
    input  logic             ld_ctx_ack,
    output logic [PTR_W-1:0] saved_data_ptr,
    output logic [PTR_W-1:0] group_down_ptr,
    output logic [2:0]       chan_state,
    output logic             irq
);

    localparam int PTR_SDATA = 1;
    localparam int PTR_GDOWN = NPTR - 1;

    logic [NPTR-1:0][PTR_W-1:0] ptr_flat;
    logic [1:0]       cfg_q;
    logic             cmd_q;
    logic [SC_W-1:0]  scmd_q;
    logic [1:0]       src_q;
    logic             err_q;
    logic [IRQ_W-1:0] irq_raw, irq_mask, irq_masked;
    logic             eol_q;
    ch_state_e        st;
    logic             cfg_wr, cmd_wr, scmd_wr, stat_rd, bad_bits;
    logic [31:0]      rd_mux;

    assign cfg_wr   = wr_en && (addr == OFS_CFG);
    assign cmd_wr   = wr_en && (addr == OFS_CMD);
    assign scmd_wr  = wr_en && (addr == OFS_SCMD);
    assign stat_rd  = rd_en && (addr == OFS_STAT);
    assign bad_bits = (cmd_wr && (wdata[31:1] != '0)) ||
                      (scmd_wr && (wdata[31:SC_W] != '0));

    generate
        for (genvar g = 0; g < NPTR; g++) begin : g_ptr
            logic [PTR_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                              q <= '0;
                else if (wr_en && addr == ptr_ofs(g)) q <= wdata[PTR_W-1:0];
            end
            assign ptr_flat[g] = q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            cmd_q  <= 1'b0;
            scmd_q <= '0;
            src_q  <= SRC_RESET;
            err_q  <= 1'b0;
        end else begin
            if (cfg_wr)  cfg_q <= wdata[1:0];
            if (cmd_wr)  cmd_q <= wdata[0];
            if (scmd_wr) begin
                scmd_q <= wdata[SC_W-1:0];
                src_q  <= SRC_SW;
            end
            if (stat_rd)  err_q <= 1'b0;
            if (bad_bits) err_q <= 1'b1;
        end
    end

    dmacr_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_i    (intr_set),
        .ack_wr   (wr_en && (addr == OFS_IACK)),
        .mask_wr  (wr_en && (addr == OFS_IMASK)),
        .wbits    (wdata[IRQ_W-1:0]),
        .raw_o    (irq_raw),
        .mask_o   (irq_mask),
        .masked_o (irq_masked),
        .irq_o    (irq)
    );

    dmacr_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr       (cfg_wr),
        .cfg_en_new   (wdata[0]),
        .cfg_stop_new (wdata[1]),
        .cfg_en_q     (cfg_q[0]),
        .cfg_stop_q   (cfg_q[1]),
        .scmd_wr      (scmd_wr),
        .scmd         (decode_scmd(wdata[SC_W-1:0])),
        .cmd_wr       (cmd_wr),
        .client       (client_present),
        .desc_eol     (desc_eol),
        .eol_hit      (eol_hit),
        .d_ack        (ld_data_ack),
        .c_ack        (ld_ctx_ack),
        .state_o      (st),
        .eol_o        (eol_q),
        .d_req        (ld_data_req),
        .c_req        (ld_ctx_req)
    );

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NPTR; i++)
            if (addr == ptr_ofs(i)) rd_mux = 32'(ptr_flat[i]);
        case (addr)
            OFS_CMD:   rd_mux = {31'b0, cmd_q};
            OFS_CFG:   rd_mux = {30'b0, cfg_q};
            OFS_STAT:  rd_mux = pack_status(st, eol_q, err_q, src_q);
            OFS_IMASK: rd_mux = 32'(irq_mask);
            OFS_IRAW:  rd_mux = 32'(irq_raw);
            OFS_IMSKD: rd_mux = 32'(irq_masked);
            OFS_SCMD:  rd_mux = 32'(scmd_q);
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign saved_data_ptr = ptr_flat[PTR_SDATA];
    assign group_down_ptr = ptr_flat[PTR_GDOWN];
    assign chan_state     = st;

endmodule

// File: rtl/dmacr_chk.sv
module dmacr_chk #(
    parameter int IRQ_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic [31:0]      wdata,
    input logic             client_present,
    input logic             eol_hit,
    input logic [IRQ_W-1:0] intr_set,
    input logic             ld_data_req,
    input logic             ld_data_ack,
    input logic             ld_ctx_req,
    input logic             ld_ctx_ack,
    input logic [2:0]       chan_state,
    input logic             irq,
    input logic [IRQ_W-1:0] raw,
    input logic             eol_flag
);

    // R1: reset leaves the channel in reset state with no requests
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (chan_state == 3'b001 && !ld_data_req && !ld_ctx_req));

    // R3: state stays one-hot
    a_r3_onehot_state: assert property (@(posedge clk) disable iff (rst)
        $countones(chan_state) == 1);

    // R5: data load request held until acknowledged
    a_r5_data_req_hold: assert property (@(posedge clk) disable iff (rst)
        (ld_data_req && !ld_data_ack) |=> ld_data_req);

    // R5: context load request held until acknowledged
    a_r5_ctx_req_hold: assert property (@(posedge clk) disable iff (rst)
        (ld_ctx_req && !ld_ctx_ack) |=> ld_ctx_req);

    // R6: no start without a client
    a_r6_no_client_no_run: assert property (@(posedge clk) disable iff (rst)
        (!client_present && chan_state != 3'b100) |=> chan_state != 3'b100);

    // R8: acknowledged bits are clear afterwards when nothing sets them
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h90 && intr_set == '0) |=>
            ((raw & $past(wdata[IRQ_W-1:0])) == '0));

    // R8: interrupt rises only after a set pulse or a mask write
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(intr_set) != '0 || $past(wr_en && addr == 8'h8C)));

    // R10: end-of-list pulse sets the flag
    a_r10_eol_set: assert property (@(posedge clk) disable iff (rst)
        eol_hit |=> eol_flag);

endmodule

bind dma_chan_regs dmacr_chk #(.IRQ_W(IRQ_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .addr           (addr),
    .wdata          (wdata),
    .client_present (client_present),
    .eol_hit        (eol_hit),
    .intr_set       (intr_set),
    .ld_data_req    (ld_data_req),
    .ld_data_ack    (ld_data_ack),
    .ld_ctx_req     (ld_ctx_req),
    .ld_ctx_ack     (ld_ctx_ack),
    .chan_state     (chan_state),
    .irq            (irq),
    .raw            (irq_raw),
    .eol_flag       (eol_q)
);

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;

    localparam int IRQ_W = 4;
    localparam int PTR_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic client_present = 1'b0, desc_eol = 1'b0, eol_hit = 1'b0;
    logic [IRQ_W-1:0] intr_set = '0;
    logic ld_data_req, ld_data_ack = 1'b0, ld_ctx_req, ld_ctx_ack = 1'b0;
    logic [PTR_W-1:0] saved_data_ptr, group_down_ptr;
    logic [2:0] chan_state;
    logic irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    dma_chan_regs #(.IRQ_W(IRQ_W), .PTR_W(PTR_W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .client_present(client_present),
        .desc_eol(desc_eol), .eol_hit(eol_hit), .intr_set(intr_set),
        .ld_data_req(ld_data_req), .ld_data_ack(ld_data_ack),
        .ld_ctx_req(ld_ctx_req), .ld_ctx_ack(ld_ctx_ack),
        .saved_data_ptr(saved_data_ptr), .group_down_ptr(group_down_ptr),
        .chan_state(chan_state), .irq(irq)
    );

    // behavioural reference model
    int m_st, m_src;
    bit m_eol, m_err, m_dreq, m_creq, m_dst, m_dcont;
    bit [1:0] m_cfg;
    bit [IRQ_W-1:0] m_raw, m_mask;
    bit dd, cc, go, cont, scw, n_err;

    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (rst) begin
            m_st = 1; m_src = 1; m_eol = 0; m_err = 0; m_dreq = 0; m_creq = 0;
            m_dst = 0; m_dcont = 0; m_cfg = 0; m_raw = 0; m_mask = 0;
        end else begin
            dd   = m_dreq && ld_data_ack;
            cc   = m_creq && ld_ctx_ack;
            go   = client_present && ((dd && (m_dst || (m_dcont && !desc_eol && m_eol))) || cc);
            cont = wr_en && addr == 8'h80 && m_cfg[0] && client_present && !m_cfg[1]
                   && m_st == 4 && desc_eol;
            scw  = wr_en && addr == 8'h9C;
            n_err = m_err;
            if (rd_en && addr == 8'h88) n_err = 0;
            if (wr_en && addr == 8'h80 && wdata[31:1] != 0) n_err = 1;
            if (scw && wdata[31:10] != 0) n_err = 1;
            if (dd) m_dreq = 0;
            if (cc) m_creq = 0;
            if (scw && (wdata & 32'h140) != 0) begin m_dreq = 1; m_dst = wdata[5]; m_dcont = 0; end
            else if (cont) begin m_dreq = 1; m_dst = 0; m_dcont = 1; end
            if (scw && wdata[9]) m_creq = 1;
            if (scw) m_src = 2;
            if (go) begin m_st = 4; m_eol = 0; end
            if (eol_hit) m_eol = 1;
            if (wr_en && addr == 8'h84) begin
                m_cfg = wdata[1:0];
                if (wdata[1]) m_st = 2;
                if (!wdata[0]) m_st = 1;
            end
            if (wr_en && addr == 8'h90) m_raw = m_raw & ~wdata[IRQ_W-1:0];
            m_raw = m_raw | intr_set;
            if (wr_en && addr == 8'h8C) m_mask = wdata[IRQ_W-1:0];
            m_err = n_err;
        end
    end

    function automatic logic [31:0] m_status();
        return {22'b0, 2'(m_src), 1'b0, m_err, m_eol, 2'b0, 3'(m_st)};
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (started && !rst) begin
            total++;
            if (chan_state !== 3'(m_st)) begin
                bad++; $display("FAIL R3 state act=%b exp=%b", chan_state, 3'(m_st));
            end
            total++;
            if (irq !== |(m_raw & m_mask)) begin
                bad++; $display("FAIL R8 irq act=%b exp=%b", irq, |(m_raw & m_mask));
            end
            total++;
            if (ld_data_req !== m_dreq || ld_ctx_req !== m_creq) begin
                bad++; $display("FAIL R5 req act=%b%b exp=%b%b",
                                ld_data_req, ld_ctx_req, m_dreq, m_creq);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0;
        total++;
        if (rdata !== exp) begin
            bad++; $display("FAIL %s addr=%h act=%h exp=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic ack_d();
        @(negedge clk); ld_data_ack = 1;
        @(negedge clk); ld_data_ack = 0;
    endtask

    task automatic ack_c();
        @(negedge clk); ld_ctx_ack = 1;
        @(negedge clk); ld_ctx_ack = 0;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++; $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        wait (cycles > 100000);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset values
        rd(8'h00, 32'h0, "R1"); rd(8'h58, 32'h0, "R1"); rd(8'h5C, 32'h0, "R1");
        rd(8'h60, 32'h0, "R1"); rd(8'h7C, 32'h0, "R1"); rd(8'h80, 32'h0, "R1");
        rd(8'h84, 32'h0, "R1"); rd(8'h88, 32'h101, "R1"); rd(8'h8C, 32'h0, "R1");
        rd(8'h94, 32'h0, "R1"); rd(8'h98, 32'h0, "R1"); rd(8'h9C, 32'h0, "R1");
        chk(irq, 1'b0, "R1 irq");

        // R2 pointers
        wr(8'h00, 32'h1111_0000); wr(8'h58, 32'h2222_0058); wr(8'h5C, 32'h3333_005C);
        wr(8'h60, 32'h4444_0060); wr(8'h7C, 32'h5555_007C);
        rd(8'h00, 32'h1111_0000, "R2"); rd(8'h58, 32'h2222_0058, "R2");
        rd(8'h5C, 32'h3333_005C, "R2"); rd(8'h60, 32'h4444_0060, "R2");
        rd(8'h7C, 32'h5555_007C, "R2");
        total++;
        if (saved_data_ptr !== 32'h2222_0058 || group_down_ptr !== 32'h5555_007C) begin
            bad++; $display("FAIL R2 ptr outputs act=%h/%h exp=22220058/5555007c",
                            saved_data_ptr, group_down_ptr);
        end

        // R3 configuration
        wr(8'h84, 32'h1); rd(8'h84, 32'h1, "R2"); rd(8'h88, 32'h101, "R3 en only");
        wr(8'h84, 32'h3); rd(8'h88, 32'h102, "R3 stop");
        wr(8'h84, 32'h2); rd(8'h88, 32'h101, "R3 reset wins");

        // R5 plain data load: no start
        client_present = 1;
        wr(8'h9C, 32'h140);
        repeat (3) @(negedge clk);
        chk(ld_data_req, 1'b1, "R5 hold");
        ack_d();
        chk(ld_data_req, 1'b0, "R5 drop");
        rd(8'h88, 32'h201, "R4 src no start");
        rd(8'h9C, 32'h140, "R5 readback");

        // R5 burst data load starts
        wr(8'h9C, 32'h160); ack_d();
        rd(8'h88, 32'h204, "R5 burst start");

        // R10 eol, R6 context start clears it
        @(negedge clk); eol_hit = 1; @(negedge clk); eol_hit = 0;
        rd(8'h88, 32'h224, "R10");
        wr(8'h9C, 32'h200);
        chk(ld_ctx_req, 1'b1, "R5 ctx req");
        ack_c();
        rd(8'h88, 32'h204, "R6 eol cleared");

        // R6 no client: no start
        wr(8'h84, 32'h0); client_present = 0;
        wr(8'h9C, 32'h200); ack_c();
        rd(8'h88, 32'h201, "R6 no client");

        // R7 continue
        client_present = 1;
        wr(8'h84, 32'h1);
        wr(8'h9C, 32'h160); ack_d();
        @(negedge clk); eol_hit = 1; @(negedge clk); eol_hit = 0;
        desc_eol = 0;
        wr(8'h80, 32'h1);
        chk(ld_data_req, 1'b0, "R7 no eol no req");
        desc_eol = 1;
        wr(8'h80, 32'h1);
        chk(ld_data_req, 1'b1, "R7 req");
        desc_eol = 0;
        ack_d();
        rd(8'h88, 32'h204, "R7 resumed");
        wr(8'h84, 32'h3); desc_eol = 1;
        wr(8'h80, 32'h1);
        chk(ld_data_req, 1'b0, "R7 stopped no req");
        desc_eol = 0;

        // R8 interrupts
        wr(8'h8C, 32'h5);
        @(negedge clk); intr_set = 4'h3; @(negedge clk); intr_set = 0;
        rd(8'h94, 32'h3, "R8 raw"); rd(8'h98, 32'h1, "R8 masked");
        chk(irq, 1'b1, "R8 irq high");
        wr(8'h90, 32'h1);
        rd(8'h94, 32'h2, "R8 ack"); rd(8'h90, 32'h0, "R8 ack reads 0");
        chk(irq, 1'b0, "R8 irq low");
        @(negedge clk); intr_set = 4'h4; wr_en = 1; addr = 8'h90; wdata = 32'h4;
        @(negedge clk); intr_set = 0; wr_en = 0; wdata = 0;
        rd(8'h94, 32'h6, "R8 set wins");
        chk(irq, 1'b1, "R8 irq set");
        wr(8'h8C, 32'h0);
        chk(irq, 1'b0, "R8 mask off");

        // R9 error flag
        wr(8'h80, 32'h3);
        rd(8'h80, 32'h1, "R9 cmd bits");
        rd(8'h88, m_status(), "R9 err set");
        rd(8'h88, m_status(), "R9 err cleared");
        total++;
        if (m_err) begin bad++; $display("FAIL R9 model err act=1 exp=0"); end
        wr(8'h9C, 32'h400);
        chk(ld_data_req, 1'b0, "R9 no data req");
        chk(ld_ctx_req, 1'b0, "R9 no ctx req");
        rd(8'h9C, 32'h0, "R9 scmd bits");
        rd(8'h88, 32'h242, "R9 err status");

        // R11 read-only / undecoded
        wr(8'h94, 32'hF); wr(8'h98, 32'hF); wr(8'h88, 32'hFFFF); wr(8'hF0, 32'h1234);
        rd(8'h94, 32'h6, "R11 raw"); rd(8'h98, 32'h0, "R11 masked");
        rd(8'h88, 32'h202, "R11 status"); rd(8'hF0, 32'h0, "R11 undecoded");
        rd(8'h00, 32'h1111_0000, "R11 ptr");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule